// File: doc/BRIEF.md
# Performance Counter Bank with Negative-Condition Alert

This block holds six 32-bit event counters and one 64-bit control word. Each counter adds one for its event on every clock where that event is present and the counter is not frozen. Four counters have an 8-bit selector in the control word. They count the cycle strobe when the selector holds 0x1E and the generic event strobe otherwise. The fifth counter counts completed instructions and the sixth always counts cycles. Software reaches the control word and every counter through one register port, which has a write strobe and a read path with no wait.

A counter is negative when its bit 31 is set. When a negative counter's condition enable is on, the block raises a sticky alert. The first counter has its own enable, and the other five share one. The alert stays set until software writes the control word. An exception-request output follows the alert while a separate escalation enable in the control word is set.

Top module: `perf_counter_bank`

## Requirements
- R1: After a synchronous active-low reset, the control word reads 0x0000_0000_8000_0000 (only the global freeze set), all six counters read 0, and both `alert` and `exc_req` are low.
- R2: Address 0 selects the control word and addresses 1 to 6 select counters 1 to 6. A counter write loads the low 32 bits of `wr_data` and takes priority over counting. Reads are combinational, and a counter is zero-extended to 64 bits.
- R3: Counter 6 counts `ev_cycle` and counter 5 counts `ev_inst`, one per clock in which the strobe is high.
- R4: Counter k (k = 1..4) uses selector bits [32+8(k-1)+7 : 32+8(k-1)]. It counts `ev_cycle` when the selector equals 0x1E and `ev_generic` otherwise.
- R5: Control bit 31 freezes all counters. Bit 5 freezes counters 1 to 4 and bit 4 freezes counters 5 and 6. A frozen counter keeps its value.
- R6: Counters wrap modulo 2^32, so 0xFFFF_FFFE plus three increments reads 0x0000_0001.
- R7: A counter at or above 0x8000_0000 whose condition enable is set makes `alert` rise one clock after that state exists. Counter 1 uses control bit 15 and counters 2 to 6 use control bit 14.
- R8: Each enable covers only its own counters. A negative counter 1 with only bit 14 set raises no alert, and a negative counter with both enables clear raises no alert.
- R9: A counter write with a negative value, or a control write that turns on the enable of an already-negative counter, raises `alert` on the clock after the write.
- R10: `alert` is sticky and survives a rewrite of the counter to a positive value. Any control write clears it unless an enabled counter is negative. Control bit 7 reads the alert and ignores writes.
- R11: `exc_req` is high exactly while `alert` is high and control bit 20 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0 control, 1..6 counters) |
| wr_data | input | 64 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 64 | Read data for `rd_addr` |
| ev_cycle | input | 1 | Cycle event strobe |
| ev_inst | input | 1 | Completed-instruction strobe |
| ev_generic | input | 1 | Generic event strobe |
| alert | output | 1 | Sticky performance-monitor alert |
| exc_req | output | 1 | Event-based exception request |

## Verification
The hardest case is a counter that crosses into the negative range by counting, not by a write. Reaching it from the ports would take about 2^31 events. The stimulus writes a counter to 0x7FFF_FFFE and applies single generic pulses, so the crossing happens on a known edge. The bench then samples `alert` on the clock before and the clock after that edge. The same timing check is repeated for turning on an enable while a counter is already negative. It is repeated again for a control write that tries to clear the alert while an enabled counter is still negative.

// File: rtl/pcb_pkg.sv
// Package: control-word bit positions and counter role encoding shared
// by the counter bank. Assumes a 64-bit control word, LSB-0 numbering.
package pcb_pkg;
    localparam int CTRL_W       = 64;
    localparam int FRZ_ALL_BIT  = 31;  // freeze every counter
    localparam int FRZ_LO_BIT   = 5;   // freeze selectable counters
    localparam int FRZ_HI_BIT   = 4;   // freeze instruction/cycle counters
    localparam int CE_FIRST_BIT = 15;  // condition enable, counter 1
    localparam int CE_REST_BIT  = 14;  // condition enable, counters 2..N
    localparam int EBE_BIT      = 20;  // escalate alert to exception
    localparam int ALERT_BIT    = 7;   // read-only sticky alert view
    localparam int SEL_BASE     = 32;  // first selector field

    typedef enum logic [1:0] {
        SRC_SELECT = 2'd0,
        SRC_INST   = 2'd1,
        SRC_CYCLE  = 2'd2
    } ctr_src_e;
endpackage

// File: rtl/pcb_counter.sv
// One counter: loads on a write, otherwise adds one for its event while
// not frozen. Assumes the event bit is already selected by the parent.
module pcb_counter #(
    parameter int CTR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CTR_W-1:0] load_val,
    input  logic             frozen,
    input  logic             evt,
    output logic [CTR_W-1:0] cnt,
    output logic             negative
);
    // Count register: reset, write priority, then gated increment.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (!frozen && evt)
            cnt <= cnt + CTR_W'(1);
    end

    // Sign bit marks the negative condition.
    always_comb negative = cnt[CTR_W-1];

    // R5
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !load) |=> $stable(cnt));
    // R2
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(load_val)));
    // R6
    step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frozen && !load && evt) |=> (cnt == $past(cnt) + CTR_W'(1)));
endmodule

// File: rtl/pcb_ctrl_reg.sv
// Control word storage. The alert bit position is never stored here;
// the parent overlays the live alert on reads. Assumes a 64-bit word.
module pcb_ctrl_reg (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr,
    input  logic [pcb_pkg::CTRL_W-1:0] wr_data,
    output logic [pcb_pkg::CTRL_W-1:0] ctrl_q
);
    import pcb_pkg::*;

    localparam logic [CTRL_W-1:0] RESET_VAL  = CTRL_W'(1) << FRZ_ALL_BIT;
    localparam logic [CTRL_W-1:0] STORE_MASK = ~(CTRL_W'(1) << ALERT_BIT);

    // Control register: global freeze at reset, masked software writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= RESET_VAL;
        else if (wr)
            ctrl_q <= wr_data & STORE_MASK;
    end

    // R10
    alert_slot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> !ctrl_q[ALERT_BIT]);
endmodule

// File: rtl/pcb_alert.sv
// Sticky alert: set when any enabled counter is negative, cleared by a
// control write. Assumes index 0 is counter 1 with its own enable.
module pcb_alert #(
    parameter int NUM_CTRS = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctrl_wr,
    input  logic [NUM_CTRS-1:0] neg_vec,
    input  logic                en_first,
    input  logic                en_rest,
    output logic                alert_q
);
    logic [NUM_CTRS-1:0] en_vec;
    logic [NUM_CTRS-1:0] hit;

    // Per-counter condition enable mask.
    always_comb begin
        en_vec    = {NUM_CTRS{en_rest}};
        en_vec[0] = en_first;
        hit       = neg_vec & en_vec;
    end

    // Sticky alert register with write-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            alert_q <= 1'b0;
        else
            alert_q <= (ctrl_wr ? 1'b0 : alert_q) | (|hit);
    end

    // R10
    alert_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alert_q && !ctrl_wr) |=> alert_q);
    // R7
    alert_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> alert_q);
endmodule

// File: rtl/perf_counter_bank.sv
// Top: six event counters, a control word and the negative-condition
// alert. Counters 1..NUM_SEL are selectable, then one instruction
// counter, then one cycle counter. Assumes a single clock domain.
module perf_counter_bank #(
    parameter int         CTR_W    = 32,
    parameter int         NUM_SEL  = 4,
    parameter int         SEL_W    = 8,
    parameter logic [7:0] CYC_CODE = 8'h1E
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [63:0] wr_data,
    input  logic [2:0]  rd_addr,
    output logic [63:0] rd_data,
    input  logic        ev_cycle,
    input  logic        ev_inst,
    input  logic        ev_generic,
    output logic        alert,
    output logic        exc_req
);
    import pcb_pkg::*;

    localparam int NUM_CTRS = NUM_SEL + 2;
    localparam int ADDR_W   = 3;

    logic [CTRL_W-1:0]   ctrl_q;
    logic                ctrl_wr;
    logic [CTR_W-1:0]    cnt_arr [NUM_CTRS];
    logic [NUM_CTRS-1:0] neg_vec;

    // Control-word write decode.
    always_comb ctrl_wr = wr_en && (wr_addr == '0);

    pcb_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (ctrl_wr),
        .wr_data (wr_data),
        .ctrl_q  (ctrl_q)
    );

    for (genvar i = 0; i < NUM_CTRS; i++) begin : g_ctr
        localparam ctr_src_e SRC = (i < NUM_SEL) ? SRC_SELECT :
                                   (i == NUM_SEL) ? SRC_INST : SRC_CYCLE;
        logic evt;
        logic frozen;
        logic load;

        // Event source, freeze group and write hit for this counter.
        if (SRC == SRC_SELECT) begin : g_sel
            always_comb begin
                evt    = (ctrl_q[SEL_BASE + SEL_W*i +: SEL_W] == SEL_W'(CYC_CODE))
                         ? ev_cycle : ev_generic;
                frozen = ctrl_q[FRZ_ALL_BIT] | ctrl_q[FRZ_LO_BIT];
            end
        end else if (SRC == SRC_INST) begin : g_inst
            always_comb begin
                evt    = ev_inst;
                frozen = ctrl_q[FRZ_ALL_BIT] | ctrl_q[FRZ_HI_BIT];
            end
        end else begin : g_cyc
            always_comb begin
                evt    = ev_cycle;
                frozen = ctrl_q[FRZ_ALL_BIT] | ctrl_q[FRZ_HI_BIT];
            end
        end

        // Counter write decode.
        always_comb load = wr_en && (wr_addr == ADDR_W'(i + 1));

        pcb_counter #(.CTR_W(CTR_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load),
            .load_val (wr_data[CTR_W-1:0]),
            .frozen   (frozen),
            .evt      (evt),
            .cnt      (cnt_arr[i]),
            .negative (neg_vec[i])
        );
    end

    pcb_alert #(.NUM_CTRS(NUM_CTRS)) u_alert (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (ctrl_wr),
        .neg_vec  (neg_vec),
        .en_first (ctrl_q[CE_FIRST_BIT]),
        .en_rest  (ctrl_q[CE_REST_BIT]),
        .alert_q  (alert)
    );

    // Escalation gate for the exception request.
    always_comb exc_req = alert & ctrl_q[EBE_BIT];

    // Read mux: control word with live alert, or zero-extended counter.
    always_comb begin
        rd_data = '0;
        if (rd_addr == '0) begin
            rd_data            = ctrl_q;
            rd_data[ALERT_BIT] = alert;
        end
        for (int i = 0; i < NUM_CTRS; i++)
            if (rd_addr == ADDR_W'(i + 1))
                rd_data = 64'(cnt_arr[i]);
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (ctrl_q[FRZ_ALL_BIT] && !alert && (cnt_arr[NUM_CTRS-1] == '0)
                    && (cnt_arr[0] == '0)));
    // R11
    exc_needs_alert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> alert);
endmodule

// File: tb/perf_counter_bank_tb.sv
`timescale 1ns/100ps
// Scoreboard bench: driver tasks queue expected items, a monitor on the
// falling edge pops and compares them.
module perf_counter_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [63:0] rd_data;
    logic        ev_cycle = 1'b0, ev_inst = 1'b0, ev_generic = 1'b0;
    logic        alert, exc_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    typedef struct {
        int          kind;   // 0 read data, 1 alert, 2 exc_req
        logic [63:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    perf_counter_bank dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ev_cycle(ev_cycle), .ev_inst(ev_inst), .ev_generic(ev_generic),
        .alert(alert), .exc_req(exc_req)
    );

    // Monitor: compare queued expectations mid-cycle.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [63:0] act;
            it  = sb_q.pop_front();
            act = (it.kind == 0) ? rd_data :
                  (it.kind == 1) ? {63'b0, alert} : {63'b0, exc_req};
            n_checks++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s kind=%0d actual=%h expected=%h",
                         it.tag, it.kind, act, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk); #0.5;
    endtask

    task automatic chk(input int kind, input logic [2:0] a,
                       input logic [63:0] exp, input string tag);
        item_t it;
        if (kind == 0) rd_addr = a;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        step();
    endtask

    task automatic wr(input logic [2:0] a, input logic [63:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic c, input logic i, input logic g, input int n);
        ev_cycle = c; ev_inst = i; ev_generic = g;
        repeat (n) step();
        ev_cycle = 0; ev_inst = 0; ev_generic = 0;
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        // R1 reset state
        chk(0, 0, 64'h0000_0000_8000_0000, "R1 ctrl");
        for (int k = 1; k <= 6; k++) chk(0, 3'(k), 64'h0, "R1 counter");
        chk(1, 0, 64'h0, "R1 alert");
        chk(2, 0, 64'h0, "R1 exc_req");

        // R2 register access
        wr(0, 64'h0000_001E_0010_4080);
        chk(0, 0, 64'h0000_001E_0010_4000, "R2 ctrl readback / R10 alert bit ignored");
        wr(0, 64'h0);
        wr(3, 64'hABCD_0000_1234_5678);
        chk(0, 3, 64'h0000_0000_1234_5678, "R2 counter low half");
        for (int k = 1; k <= 6; k++) wr(3'(k), 64'h0);

        // R3 fixed sources
        pulse(1, 0, 0, 5);
        pulse(0, 1, 0, 3);
        chk(0, 6, 64'd5, "R3 counter6 cycles");
        chk(0, 5, 64'd3, "R3 counter5 instructions");
        chk(0, 1, 64'd0, "R4 counter1 ignores cycles with selector 0");

        // R4 selector
        wr(0, 64'h0000_001E_0000_0000);
        pulse(1, 0, 0, 4);
        chk(0, 1, 64'd4, "R4 counter1 cycles at code 0x1E");
        chk(0, 2, 64'd0, "R4 counter2 not on cycles");
        pulse(0, 0, 1, 2);
        chk(0, 2, 64'd2, "R4 counter2 generic");
        chk(0, 4, 64'd2, "R4 counter4 generic");
        chk(0, 1, 64'd4, "R4 counter1 not on generic");

        // R5 freeze groups
        for (int k = 1; k <= 6; k++) wr(3'(k), 64'h0);
        wr(0, 64'h20);
        pulse(1, 1, 1, 3);
        chk(0, 2, 64'd0, "R5 low group frozen");
        chk(0, 5, 64'd3, "R5 counter5 runs");
        chk(0, 6, 64'd3, "R5 counter6 runs");
        wr(0, 64'h10);
        pulse(1, 1, 1, 2);
        chk(0, 1, 64'd2, "R5 counter1 runs");
        chk(0, 6, 64'd3, "R5 high group frozen");
        wr(0, 64'h8000_0000);
        pulse(1, 1, 1, 2);
        chk(0, 1, 64'd2, "R5 global freeze counter1");
        chk(0, 5, 64'd3, "R5 global freeze counter5");

        // R6 wrap, no alert without enables
        wr(0, 64'h0);
        wr(6, 64'hFFFF_FFFE);
        pulse(1, 0, 0, 3);
        chk(0, 6, 64'h1, "R6 wrap");
        chk(1, 0, 64'h0, "R8 no enable no alert");

        // R7 crossing by counting
        wr(2, 64'h7FFF_FFFE);
        wr(0, 64'h4000);
        pulse(0, 0, 1, 1);
        chk(1, 0, 64'h0, "R7 below threshold");
        pulse(0, 0, 1, 1);
        chk(1, 0, 64'h0, "R7 one clock after crossing edge not yet");
        chk(1, 0, 64'h1, "R7 alert raised");
        chk(2, 0, 64'h0, "R11 no exc without enable");

        // R10 sticky, cleared by control write
        wr(2, 64'd5);
        chk(1, 0, 64'h1, "R10 sticky after positive rewrite");
        chk(0, 0, 64'h0000_0000_0000_4080, "R10 alert visible in ctrl");
        wr(0, 64'h4000);
        chk(1, 0, 64'h0, "R10 cleared by control write");

        // R8 enable separation, R9 enable on negative counter
        wr(1, 64'h8000_0000);
        chk(1, 0, 64'h0, "R8 counter1 ignores shared enable");
        chk(1, 0, 64'h0, "R8 counter1 still no alert");
        wr(0, 64'h8000);
        chk(1, 0, 64'h0, "R9 enable write edge");
        chk(1, 0, 64'h1, "R9 alert after enable write");
        wr(1, 64'h0);
        wr(0, 64'h0);
        chk(1, 0, 64'h0, "R10 clear");

        // R9 negative write, R11 escalation
        wr(0, 64'h0010_4000);
        wr(4, 64'h9000_0000);
        chk(1, 0, 64'h0, "R9 write edge");
        chk(1, 0, 64'h1, "R9 alert after negative write");
        chk(2, 0, 64'h1, "R11 exc_req with enable");
        wr(0, 64'h4000);
        chk(2, 0, 64'h0, "R11 exc_req drops with enable");
        chk(1, 0, 64'h1, "R10 clear blocked by negative counter");

        step();
        done = 1;
        summary();
    end
endmodule